// File: doc/BRIEF.md
# Semi-Transparent Pixel Blend Stage

This block sits between a rasteriser and a 16-bit frame buffer. Each frame-buffer word holds three 5-bit colour channels and a mask flag in bit 15. For every pixel the block receives three inputs: an 8-bit-per-channel foreground colour, the background word already stored at that location, and control flags. It then decides whether the pixel may be written, and it produces the word to store. When semi-transparency applies, each channel is combined with the background using one of four fixed equations. The working width is 8 bits per channel: the stored 5-bit value is moved up three places, combined with the foreground, limited to the channel range, and cut back to 5 bits. Otherwise the foreground is written as an opaque colour.

The active equation comes from a 2-bit mode held in a small register. A draw-mode command loads that register, and so does the page word that travels with a textured primitive. The newer of the two takes effect. The output side is a two-state machine. `ST_IDLE` means no result is pending. `ST_EMIT` means a result is presented on the output this cycle. The transitions are: `ST_IDLE -> ST_EMIT` on an accepted pixel, `ST_EMIT -> ST_EMIT` on a back-to-back pixel, `ST_EMIT -> ST_IDLE` when no pixel arrives, and `ST_IDLE -> ST_IDLE` while idle.

Top module: `pxblend_unit`

## Requirements
- R1: With mode value 0 and blending active, each output channel is ((B8>>1)+(F8>>1))>>3, where B8 = background channel << 3 and F8 is the 8-bit foreground channel.
- R2: With mode value 1 and blending active, each channel is min(B8+F8, 255)>>3.
- R3: With mode value 2 and blending active, each channel is max(B8−F8, 0)>>3.
- R4: With mode value 3 and blending active, each channel is min(B8+(F8>>2), 255)>>3.
- R5: The channel fields are laid out the same way on both sides. In the frame-buffer word, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. In `in_fg`, red is bits 7:0, green is bits 15:8 and blue is bits 23:16. Each channel is computed independently of the others.
- R6: When `semi_en` is low, each output channel is F8>>3 regardless of the background and the mode.
- R7: When `tex_en` is high, blending happens only if `texel_msb` is 1. With `texel_msb` at 0 the pixel is written opaque as in R6.
- R8: Output bit 15 is 1 when `set_mask` is high. When `set_mask` is low, bit 15 is `texel_msb` for a textured pixel and 0 for an untextured one.
- R9: When `check_mask` is high and `in_bg` bit 15 is 1, `out_we` is 0 and `out_word` equals `in_bg`. Otherwise `out_we` is 1 for every accepted pixel.
- R10: The mode register takes bits 6:5 of `mode_cmd_word` when `mode_cmd_we` is high, and bits 6:5 of `page_word` when `page_we` is high. If both strobes are high in the same cycle, `page_word` wins. A load is used by pixels presented in later cycles, not by a pixel presented in the same cycle. The register resets to mode 0.
- R11: A pixel accepted with `in_valid` high appears with `out_valid` high exactly one cycle later, including for back-to-back pixels. `out_valid` is low after a cycle without `in_valid`, and `out_we` is never high while `out_valid` is low.
- R12: During and right after reset, `out_valid`, `out_we` and `out_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cmd_we | input | 1 | Draw-mode command strobe |
| mode_cmd_word | input | 16 | Draw-mode command payload, mode in bits 6:5 |
| page_we | input | 1 | Primitive page-word strobe |
| page_word | input | 16 | Primitive page word, mode in bits 6:5 |
| in_valid | input | 1 | Pixel present this cycle |
| in_fg | input | 24 | Foreground colour, 8 bits per channel |
| in_bg | input | 16 | Background word read from memory |
| semi_en | input | 1 | Semi-transparency requested |
| tex_en | input | 1 | Foreground comes from a texel |
| texel_msb | input | 1 | Bit 15 of that texel |
| set_mask | input | 1 | Force mask bit in written word |
| check_mask | input | 1 | Skip writes onto masked background |
| out_valid | output | 1 | Result present |
| out_we | output | 1 | Result must be written |
| out_word | output | 16 | Word to write (or old word when skipped) |

## Verification
The assertions compare each clocked result with the inputs of the previous cycle through `$past`. They therefore assume that pixel flags and words are driven to known values whenever the block is out of reset. They also assume the mode strobes carry meaningful words whenever they are high. The stimulus drives every input to a defined level at every falling edge: idle cycles hold zero, and strobes are raised only together with a real payload. Background mask bits and texel bits are set only in the vectors that target R7 to R9, so the other equation checks see unmasked backgrounds.

// File: rtl/pxblend_pkg.sv
package pxblend_pkg;

    typedef enum logic [1:0] {
        BM_AVG  = 2'd0,
        BM_ADD  = 2'd1,
        BM_SUB  = 2'd2,
        BM_QADD = 2'd3
    } blend_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;

    localparam int MODE_FIELD_LSB = 5;

endpackage

// File: rtl/pxblend_mode_reg.sv
module pxblend_mode_reg
    import pxblend_pkg::*;
#(
    parameter int PW       = 16,
    parameter int FIELD_LO = MODE_FIELD_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [PW-1:0] cmd_word,
    input  logic          pg_we,
    input  logic [PW-1:0] pg_word,
    output blend_mode_e   mode
);
    localparam int FIELD_HI = FIELD_LO + 1;

    blend_mode_e mode_q;
    blend_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (cmd_we) mode_d = blend_mode_e'(cmd_word[FIELD_HI:FIELD_LO]);
        if (pg_we)  mode_d = blend_mode_e'(pg_word[FIELD_HI:FIELD_LO]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= BM_AVG;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    // R10: without a strobe the mode holds
    a_r10_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && !pg_we) |=> $stable(mode_q));

    // R10: page word takes priority over a same-cycle command
    a_r10_page_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pg_we |=> (mode_q == $past(pg_word[FIELD_HI:FIELD_LO])));

endmodule

// File: rtl/pxblend_channel.sv
module pxblend_channel
    import pxblend_pkg::*;
#(
    parameter int CW = 5,
    parameter int FW = 8
) (
    input  blend_mode_e   mode,
    input  logic          blend_en,
    input  logic [CW-1:0] bg_c,
    input  logic [FW-1:0] fg_c,
    output logic [CW-1:0] res_c
);
    localparam int SH = FW - CW;

    logic [FW-1:0] bg_x;
    logic [FW:0]   wide;
    logic [FW-1:0] sat;

    assign bg_x = FW'(bg_c) << SH;

    always_comb begin
        unique case (mode)
            BM_AVG:  wide = (FW+1)'(bg_x >> 1) + (FW+1)'(fg_c >> 1);
            BM_ADD:  wide = (FW+1)'(bg_x) + (FW+1)'(fg_c);
            BM_SUB:  wide = (fg_c > bg_x) ? '0 : (FW+1)'(bg_x - fg_c);
            BM_QADD: wide = (FW+1)'(bg_x) + (FW+1)'(fg_c >> 2);
        endcase
        sat   = wide[FW] ? {FW{1'b1}} : wide[FW-1:0];
        res_c = blend_en ? sat[FW-1:SH] : fg_c[FW-1:SH];
    end

    // R3: subtraction never brightens; R2/R4: additions never darken
    always_comb begin
        if (blend_en && mode == BM_SUB)
            a_r3_sub_not_above_bg: assert (res_c <= bg_c);
        if (blend_en && (mode == BM_ADD || mode == BM_QADD))
            a_r2_add_not_below_bg: assert (res_c >= bg_c);
    end

endmodule

// File: rtl/pxblend_unit.sv
module pxblend_unit
    import pxblend_pkg::*;
#(
    parameter int CW  = 5,
    parameter int FW  = 8,
    parameter int NCH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_cmd_we,
    input  logic [NCH*CW:0]   mode_cmd_word,
    input  logic              page_we,
    input  logic [NCH*CW:0]   page_word,
    input  logic              in_valid,
    input  logic [NCH*FW-1:0] in_fg,
    input  logic [NCH*CW:0]   in_bg,
    input  logic              semi_en,
    input  logic              tex_en,
    input  logic              texel_msb,
    input  logic              set_mask,
    input  logic              check_mask,
    output logic              out_valid,
    output logic              out_we,
    output logic [NCH*CW:0]   out_word
);
    localparam int WW       = NCH * CW + 1;
    localparam int MASK_BIT = WW - 1;

    blend_mode_e   cur_mode;
    logic          blend_en;
    logic          mask_next;
    logic          write_ok;
    logic [WW-1:0] word_next;
    logic [NCH*CW-1:0] colour_next;

    out_state_e state_q;
    out_state_e state_d;

    pxblend_mode_reg #(.PW(WW), .FIELD_LO(MODE_FIELD_LSB)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (mode_cmd_we),
        .cmd_word (mode_cmd_word),
        .pg_we    (page_we),
        .pg_word  (page_word),
        .mode     (cur_mode)
    );

    assign blend_en  = semi_en && (!tex_en || texel_msb);
    assign mask_next = set_mask || (tex_en && texel_msb);
    assign write_ok  = !(check_mask && in_bg[MASK_BIT]);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pxblend_channel #(.CW(CW), .FW(FW)) u_ch (
            .mode     (cur_mode),
            .blend_en (blend_en),
            .bg_c     (in_bg[ch*CW +: CW]),
            .fg_c     (in_fg[ch*FW +: FW]),
            .res_c    (colour_next[ch*CW +: CW])
        );
    end

    assign word_next = write_ok ? {mask_next, colour_next} : in_bg;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EMIT;
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_we   <= 1'b0;
            out_word <= '0;
        end else if (in_valid) begin
            out_we   <= write_ok;
            out_word <= word_next;
        end else begin
            out_we   <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r11_idle_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r11_we_within_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> out_valid);

    a_r9_skip_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && check_mask && in_bg[MASK_BIT])
            |=> (!out_we && out_word == $past(in_bg)));

    a_r8_force_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_mask && !(check_mask && in_bg[MASK_BIT]))
            |=> (out_we && out_word[MASK_BIT]));

endmodule

// File: tb/pxblend_unit_bench.sv
module pxblend_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_cmd_we = 1'b0;
    logic [15:0] mode_cmd_word = '0;
    logic        page_we = 1'b0;
    logic [15:0] page_word = '0;
    logic        in_valid = 1'b0;
    logic [23:0] in_fg = '0;
    logic [15:0] in_bg = '0;
    logic        semi_en = 1'b0;
    logic        tex_en = 1'b0;
    logic        texel_msb = 1'b0;
    logic        set_mask = 1'b0;
    logic        check_mask = 1'b0;
    logic        out_valid;
    logic        out_we;
    logic [15:0] out_word;

    always #2 clk = ~clk;

    pxblend_unit u_pxblend_unit (
        .clk(clk), .rst_n(rst_n),
        .mode_cmd_we(mode_cmd_we), .mode_cmd_word(mode_cmd_word),
        .page_we(page_we), .page_word(page_word),
        .in_valid(in_valid), .in_fg(in_fg), .in_bg(in_bg),
        .semi_en(semi_en), .tex_en(tex_en), .texel_msb(texel_msb),
        .set_mask(set_mask), .check_mask(check_mask),
        .out_valid(out_valid), .out_we(out_we), .out_word(out_word)
    );

    typedef struct {
        logic        we;
        logic [15:0] word;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    logic [1:0] model_mode = 2'd0;
    bit   done = 0;

    function automatic logic [4:0] model_ch(input logic [1:0] m, input logic [4:0] b5,
                                            input logic [7:0] f8, input bit en);
        int b8, r;
        b8 = int'(b5) * 8;
        if (!en) return f8[7:3];
        case (m)
            2'd0: r = b8 / 2 + int'(f8) / 2;
            2'd1: r = b8 + int'(f8);
            2'd2: r = b8 - int'(f8);
            default: r = b8 + int'(f8) / 4;
        endcase
        if (r > 255) r = 255;
        if (r < 0) r = 0;
        return 5'(r / 8);
    endfunction

    // driver: one pixel in one cycle; optional same-cycle mode loads
    task automatic px(input logic [7:0] fr, input logic [7:0] fg, input logic [7:0] fb,
                      input logic [15:0] bg, input bit semi, input bit tex, input bit tb,
                      input bit sm, input bit cm, input string tag,
                      input bit ldc = 0, input logic [1:0] cm_v = 0,
                      input bit ldp = 0, input logic [1:0] pm_v = 0);
        exp_t e;
        bit en;
        @(negedge clk);
        in_valid = 1'b1; in_fg = {fb, fg, fr}; in_bg = bg;
        semi_en = semi; tex_en = tex; texel_msb = tb; set_mask = sm; check_mask = cm;
        mode_cmd_we = ldc; mode_cmd_word = 16'(cm_v) << 5;
        page_we = ldp; page_word = 16'(pm_v) << 5;
        en = semi && (!tex || tb);
        e.tag = tag;
        if (cm && bg[15]) begin
            e.we = 1'b0; e.word = bg;
        end else begin
            e.we = 1'b1;
            e.word = {sm || (tex && tb),
                      model_ch(model_mode, bg[14:10], fb, en),
                      model_ch(model_mode, bg[9:5],   fg, en),
                      model_ch(model_mode, bg[4:0],   fr, en)};
        end
        q.push_back(e);
        if (ldc) model_mode = cm_v;
        if (ldp) model_mode = pm_v;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 0; mode_cmd_we = 0; page_we = 0;
            in_fg = '0; in_bg = '0; semi_en = 0; tex_en = 0;
            texel_msb = 0; set_mask = 0; check_mask = 0;
        end
    endtask

    task automatic ld(input bit c, input logic [1:0] cv, input bit p, input logic [1:0] pv);
        @(negedge clk);
        in_valid = 0;
        mode_cmd_we = c; mode_cmd_word = 16'(cv) << 5;
        page_we = p; page_word = 16'(pv) << 5;
        if (c) model_mode = cv;
        if (p) model_mode = pv;
    endtask

    // monitor: compare results as they appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (out_valid) begin
                    n_checks++;
                    if (q.size() == 0) begin
                        n_fails++;
                        $display("FAIL R11 unexpected result: got we=%0b word=%h expected none",
                                 out_we, out_word);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        if (out_we !== e.we || out_word !== e.word) begin
                            n_fails++;
                            $display("FAIL %s: got we=%0b word=%h expected we=%0b word=%h",
                                     e.tag, out_we, out_word, e.we, e.word);
                        end
                    end
                end else if (q.size() != 0) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL R11 missing result: got out_valid=0 expected 1 (we=%0b word=%h)",
                             q[0].we, q[0].word);
                    void'(q.pop_front());
                end else if (out_we !== 1'b0) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL R11 out_we without out_valid: got %0b expected 0", out_we);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL R11 watchdog expired: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [4:0] vals [3];
        vals[0] = 5'd0; vals[1] = 5'd16; vals[2] = 5'd31;

        repeat (3) @(negedge clk);
        n_checks++;  // R12 reset state
        if (out_valid !== 0 || out_we !== 0 || out_word !== 16'h0) begin
            n_fails++;
            $display("FAIL R12 reset: got v=%0b we=%0b w=%h expected 0 0 0000",
                     out_valid, out_we, out_word);
        end
        @(negedge clk); rst_n = 1'b1;

        // R10 reset mode is 0 -> R1 average without any load
        px(8'd128, 8'd0, 8'd0, 16'd16, 1, 0, 0, 0, 0, "R1 R10 default mode avg");
        idle(1);

        // R1..R4 sweep on red channel, all B/F pairs on 5-bit boundaries
        for (int m = 0; m < 4; m++) begin
            ld(1, 2'(m), 0, 0);
            for (int b = 0; b < 3; b++)
                for (int f = 0; f < 3; f++)
                    px({vals[f], 3'b0}, 8'd0, 8'd0, {11'd0, vals[b]}, 1, 0, 0, 0, 0,
                       (m == 0) ? "R1 avg" : (m == 1) ? "R2 add sat" :
                       (m == 2) ? "R3 sub clamp" : "R4 quarter add");
            idle(1);
        end

        // R5 independent channels with mixed, non-aligned values
        for (int m = 0; m < 4; m++) begin
            ld(0, 0, 1, 2'(m));
            px(8'd200, 8'd37, 8'd255, {1'b0, 5'd3, 5'd29, 5'd17}, 1, 0, 0, 0, 0, "R5 channel layout");
            px(8'd7, 8'd250, 8'd99, {1'b0, 5'd31, 5'd1, 5'd0}, 1, 0, 0, 0, 0, "R5 channel layout");
        end
        idle(2);

        // R6 opaque: background and mode ignored
        ld(1, 2'd2, 0, 0);
        px(8'd255, 8'd8, 8'd100, {1'b0, 5'd31, 5'd31, 5'd31}, 0, 0, 0, 0, 0, "R6 opaque");
        // R7 textured with texel bit clear -> opaque, bit15 follows texel
        px(8'd64, 8'd64, 8'd64, {1'b0, 5'd20, 5'd20, 5'd20}, 1, 1, 0, 0, 0, "R7 texel bit clear");
        // R7 textured with texel bit set -> blended, bit15 = 1
        px(8'd64, 8'd64, 8'd64, {1'b0, 5'd20, 5'd20, 5'd20}, 1, 1, 1, 0, 0, "R7 texel bit set");
        // R8 set mask across modes
        for (int m = 0; m < 4; m++) begin
            ld(1, 2'(m), 0, 0);
            px(8'd128, 8'd128, 8'd128, {1'b0, 5'd16, 5'd16, 5'd16}, 1, 0, 0, 1, 0, "R8 set mask");
        end
        // R9 check mask: masked background skipped, unmasked written
        px(8'd128, 8'd128, 8'd128, {1'b1, 5'd16, 5'd16, 5'd16}, 1, 0, 0, 0, 1, "R9 check mask skip");
        px(8'd128, 8'd128, 8'd128, {1'b0, 5'd16, 5'd16, 5'd16}, 1, 0, 0, 0, 1, "R9 check mask clear bg");
        px(8'd128, 8'd0, 8'd0, {1'b1, 5'd9, 5'd0, 5'd0}, 1, 0, 0, 1, 1, "R9 check beats set mask");
        idle(1);

        // R10: same-cycle load does not affect that pixel; page beats command
        ld(1, 2'd0, 0, 0);
        px(8'd128, 8'd0, 8'd0, 16'd16, 1, 0, 0, 0, 0, "R10 load with pixel uses old mode",
           1, 2'd1, 1, 2'd2);
        px(8'd128, 8'd0, 8'd0, 16'd16, 1, 0, 0, 0, 0, "R10 page word wins");
        ld(0, 0, 1, 2'd3);
        px(8'd128, 8'd0, 8'd0, 16'd16, 1, 0, 0, 0, 0, "R10 page word load");
        ld(1, 2'd1, 0, 0);
        px(8'd128, 8'd0, 8'd0, 16'd31, 1, 0, 0, 0, 0, "R10 command after page");
        idle(3);

        n_checks++;  // R11 idle output after gap
        if (out_valid !== 0 || out_we !== 0) begin
            n_fails++;
            $display("FAIL R11 idle: got v=%0b we=%0b expected 0 0", out_valid, out_we);
        end
        n_checks++;  // R11 everything drained
        if (q.size() != 0) begin
            n_fails++;
            $display("FAIL R11 pending results: got %0d expected 0", q.size());
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule